// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel

This block is one DMA channel. It copies a block of data units from a source address to a destination address over a simple memory-bus master. The data passes through a small internal FIFO: each chunk is read into the FIFO in full and then written out. The channel is set up through a configuration port that carries the source address, the destination address, a next-descriptor pointer and a control word. A one-cycle start pulse loads these values.

When a block is done and the next pointer is non-zero, the channel reads a four-word descriptor from that address and carries on with the new block. This lets a single start cover scattered memory regions. A chunk starts in one of three ways:
- The control word selects free-running mode, and the channel moves data with no request.
- A peripheral raises a burst request, which moves one burst.
- A peripheral raises a single request, which moves one unit.

A terminal-count event and a bus-error event each set a raw status flag. Each flag is then gated by an enable to form an interrupt output.

Top module: `sg_dma_chan`

## Requirements
- R1: After reset the channel is idle: `busy`, `m_valid`, `raw_tc`, `raw_err`, `irq_tc` and `irq_err` are all 0. A `cfg_start` pulse while idle sets `busy`. `busy` stays high until the whole chain ends or an error occurs. In free-running mode the channel copies `count` units from source to destination.
- R2: Data goes through a FIFO of `FIFO_DEPTH` (4) words. A chunk is at most `min(burst units, FIFO_DEPTH, units left)` units, and all reads of a chunk come before its first write. The FIFO never holds more than its depth, and a write is issued only when the FIFO holds data.
- R3: Control word bit 16 makes the source address advance after every unit, and bit 17 does the same for the destination address. The step equals the unit size. When a bit is clear, that address stays fixed.
- R4: Control word bits 15:14 select the unit width. Code 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits. In little-endian mode a unit at byte offset `a` sits in bus lanes starting at lane `a`. `m_strb` has one bit set per byte of the unit. A byte write has exactly one strobe bit.
- R5: In big-endian mode a unit of `n` bytes at offset `a` sits in lanes starting at lane `4-a-n`. `cfg_big_endian` is latched at start, and reset selects little-endian.
- R6: Control word bit 19 selects free-running mode. When it is clear, the channel moves nothing until a request arrives:
  - `req_burst` moves `min(burst units, units left)` units.
  - `req_single` moves one unit.
  - `req_done` pulses with the last write of each requested chunk.
  - Bits 13:12 give the burst as `2^code` units, clamped to the FIFO depth.
- R7: At the end of a block, a non-zero next pointer makes the channel read four words at that address. In order they are the source, the destination, the next pointer and the control word. Bits 11:0 of the control word give the count. A next pointer of zero ends the chain.
- R8: `raw_tc` is set only when the final block of a chain ends, and only if bit 18 of that block's control word is set. `irq_tc` = `raw_tc` AND `int_en[0]`. `int_clr[0]` clears `raw_tc`.
- R9: A bus error response on any access stops the channel at once (`busy` falls) and sets `raw_err`. `irq_err` = `raw_err` AND `int_en[1]`. `int_clr[1]` clears `raw_err`.
- R10: Once raised, `m_valid` stays high with `m_addr` and `m_write` unchanged until `m_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Load configuration and start (ignored while busy) |
| cfg_src | input | 32 | First block source address |
| cfg_dst | input | 32 | First block destination address |
| cfg_next | input | 32 | First next-descriptor pointer |
| cfg_ctrl | input | 20 | First block control word |
| cfg_big_endian | input | 1 | Byte-order select latched at start |
| req_single | input | 1 | Peripheral single-unit request |
| req_burst | input | 1 | Peripheral burst request |
| req_done | output | 1 | Pulse on last write of a requested chunk |
| m_valid | output | 1 | Bus access valid |
| m_write | output | 1 | Bus access is a write |
| m_addr | output | 32 | Bus byte address |
| m_wdata | output | 32 | Write data placed in lanes |
| m_strb | output | 4 | Write byte-lane strobes |
| m_rdata | input | 32 | Read data |
| m_ready | input | 1 | Access accepted this cycle |
| m_err | input | 1 | Error response, valid with `m_ready` |
| busy | output | 1 | Channel active |
| int_en | input | 2 | Interrupt enables: bit 0 terminal count, bit 1 error |
| int_clr | input | 2 | Raw status clear: bit 0 terminal count, bit 1 error |
| raw_tc | output | 1 | Raw terminal-count status |
| raw_err | output | 1 | Raw error status |
| irq_tc | output | 1 | Masked terminal-count interrupt |
| irq_err | output | 1 | Masked error interrupt |

## Verification
The properties assume the following about the inputs:
- Every source, destination and descriptor address is aligned to its unit size, so the lane and strobe rules hold.
- The bus returns `m_err` only together with `m_ready`.
- A peripheral keeps its request level until it sees `req_done`.

The bench keeps to these assumptions. It drives only aligned addresses and models a memory that answers after a one-cycle wait, with errors only in the top address region. It drops each request on the cycle that `req_done` appears, and it keeps the source and destination regions of every run apart.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int CNT_W  = 12;
    localparam int CTRL_W = 20;

    typedef enum logic [1:0] {
        WID_8   = 2'd0,
        WID_16  = 2'd1,
        WID_32  = 2'd2,
        WID_32B = 2'd3
    } wid_e;

    // Control word: [11:0] count, [13:12] burst code, [15:14] width,
    // [16] source step, [17] destination step, [18] tc interrupt,
    // [19] free-running (no peripheral request needed)
    typedef struct packed {
        logic             free_run;
        logic             tc_ie;
        logic             dst_inc;
        logic             src_inc;
        wid_e             width;
        logic [1:0]       burst;
        logic [CNT_W-1:0] count;
    } ctrl_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_RD,
        S_WR,
        S_LINK,
        S_DESC
    } eng_state_e;

    function automatic logic [2:0] unit_bytes(wid_e w);
        case (w)
            WID_8:   return 3'd1;
            WID_16:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [DW-1:0] unit_mask(wid_e w);
        case (w)
            WID_8:   return 32'h0000_00FF;
            WID_16:  return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [3:0] byte_en(wid_e w);
        case (w)
            WID_8:   return 4'b0001;
            WID_16:  return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // Bit offset of a unit inside the bus word for either byte order
    function automatic logic [4:0] lane_shift(logic [1:0] a, wid_e w, logic big);
        logic [1:0] lane;
        lane = big ? 2'(3'd4 - {1'b0, a} - unit_bytes(w)) : a;
        return {lane, 3'b000};
    endfunction

    function automatic int burst_units(logic [1:0] code, int depth);
        int u;
        u = 1 << code;
        return (u > depth) ? depth : u;
    endfunction

endpackage

// File: rtl/sgdma_fifo.sv
module sgdma_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               din,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot_q [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [LW-1:0] level_q;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_q    <= '0;
            wr_q    <= '0;
            level_q <= '0;
        end else begin
            if (push) begin
                slot_q[wr_q] <= din;
                wr_q         <= bump(wr_q);
            end
            if (pop) begin
                rd_q <= bump(rd_q);
            end
            level_q <= level_q + LW'(push) - LW'(pop);
        end
    end

    assign dout  = slot_q[rd_q];
    assign level = level_q;

endmodule

// File: rtl/sgdma_lanes.sv
module sgdma_lanes
    import sgdma_pkg::*;
(
    input  logic [DW-1:0] rd_word,
    input  logic [DW-1:0] wr_unit,
    input  logic [1:0]    addr_lo,
    input  wid_e          width,
    input  logic          big,
    output logic [DW-1:0] rd_unit,
    output logic [DW-1:0] wr_word,
    output logic [3:0]    wr_strb
);
    logic [4:0] sh;

    assign sh      = lane_shift(addr_lo, width, big);
    assign rd_unit = (rd_word >> sh) & unit_mask(width);
    assign wr_word = (wr_unit & unit_mask(width)) << sh;
    assign wr_strb = byte_en(width) << sh[4:3];

endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
    import sgdma_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [AW-1:0] cfg_next,
    input  ctrl_t         cfg_ctrl,
    input  logic          req_single,
    input  logic          req_burst,
    input  logic          m_ready,
    input  logic          m_err,
    input  logic [DW-1:0] m_rdata,
    output logic          m_valid,
    output logic          m_write,
    output logic [AW-1:0] m_addr,
    output wid_e          cur_width,
    output logic          busy,
    output logic          push,
    output logic          pop,
    output logic          flush,
    output logic          req_done,
    output logic          done_tc,
    output logic          err_evt
);
    localparam int CHW = $clog2(DEPTH + 1);

    eng_state_e       state_q;
    logic [AW-1:0]    src_q, dst_q, lli_q, dbase_q;
    ctrl_t            ctl_q;
    logic [CNT_W-1:0] left_q;
    logic [CHW-1:0]   rd_n_q, wr_n_q;
    logic [1:0]       dix_q;

    logic             full_chunk, paced_go, beat_ok;
    logic [CNT_W-1:0] bu_c, chunk_c;
    logic [AW-1:0]    step;

    assign step       = AW'(unit_bytes(ctl_q.width));
    assign full_chunk = ctl_q.free_run | req_burst;
    assign paced_go   = full_chunk | req_single;
    assign bu_c       = CNT_W'(burst_units(ctl_q.burst, DEPTH));
    assign chunk_c    = full_chunk ? ((bu_c < left_q) ? bu_c : left_q) : CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            src_q   <= '0;
            dst_q   <= '0;
            lli_q   <= '0;
            dbase_q <= '0;
            ctl_q   <= '0;
            left_q  <= '0;
            rd_n_q  <= '0;
            wr_n_q  <= '0;
            dix_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        src_q   <= cfg_src;
                        dst_q   <= cfg_dst;
                        lli_q   <= cfg_next;
                        ctl_q   <= cfg_ctrl;
                        left_q  <= cfg_ctrl.count;
                        state_q <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (left_q == '0) begin
                        state_q <= S_LINK;
                    end else if (paced_go) begin
                        rd_n_q  <= CHW'(chunk_c);
                        wr_n_q  <= CHW'(chunk_c);
                        state_q <= S_RD;
                    end
                end
                S_RD: begin
                    if (m_ready) begin
                        if (m_err) begin
                            state_q <= S_IDLE;
                        end else begin
                            if (ctl_q.src_inc) src_q <= src_q + step;
                            rd_n_q <= rd_n_q - 1'b1;
                            if (rd_n_q == CHW'(1)) state_q <= S_WR;
                        end
                    end
                end
                S_WR: begin
                    if (m_ready) begin
                        if (m_err) begin
                            state_q <= S_IDLE;
                        end else begin
                            if (ctl_q.dst_inc) dst_q <= dst_q + step;
                            left_q <= left_q - 1'b1;
                            wr_n_q <= wr_n_q - 1'b1;
                            if (wr_n_q == CHW'(1)) state_q <= S_WAIT;
                        end
                    end
                end
                S_LINK: begin
                    if (lli_q != '0) begin
                        dbase_q <= lli_q;
                        dix_q   <= '0;
                        state_q <= S_DESC;
                    end else begin
                        state_q <= S_IDLE;
                    end
                end
                S_DESC: begin
                    if (m_ready) begin
                        if (m_err) begin
                            state_q <= S_IDLE;
                        end else begin
                            case (dix_q)
                                2'd0: src_q <= m_rdata;
                                2'd1: dst_q <= m_rdata;
                                2'd2: lli_q <= m_rdata;
                                default: begin
                                    ctl_q  <= ctrl_t'(m_rdata[CTRL_W-1:0]);
                                    left_q <= m_rdata[CNT_W-1:0];
                                end
                            endcase
                            dix_q <= dix_q + 1'b1;
                            if (dix_q == 2'd3) state_q <= S_WAIT;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state_q)
            S_RD:    m_addr = src_q;
            S_WR:    m_addr = dst_q;
            S_DESC:  m_addr = dbase_q + AW'({dix_q, 2'b00});
            default: m_addr = '0;
        endcase
    end

    assign m_valid   = (state_q == S_RD) | (state_q == S_WR) | (state_q == S_DESC);
    assign m_write   = (state_q == S_WR);
    assign beat_ok   = m_valid & m_ready & ~m_err;
    assign err_evt   = m_valid & m_ready & m_err;
    assign flush     = err_evt;
    assign push      = (state_q == S_RD) & beat_ok;
    assign pop       = (state_q == S_WR) & beat_ok;
    assign req_done  = pop & (wr_n_q == CHW'(1)) & ~ctl_q.free_run;
    assign done_tc   = (state_q == S_LINK) & (lli_q == '0) & ctl_q.tc_ie;
    assign cur_width = ctl_q.width;
    assign busy      = (state_q != S_IDLE);

endmodule

// File: rtl/sg_dma_chan.sv
module sg_dma_chan
    import sgdma_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_start,
    input  logic [AW-1:0]     cfg_src,
    input  logic [AW-1:0]     cfg_dst,
    input  logic [AW-1:0]     cfg_next,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic              cfg_big_endian,
    input  logic              req_single,
    input  logic              req_burst,
    output logic              req_done,
    output logic              m_valid,
    output logic              m_write,
    output logic [AW-1:0]     m_addr,
    output logic [DW-1:0]     m_wdata,
    output logic [3:0]        m_strb,
    input  logic [DW-1:0]     m_rdata,
    input  logic              m_ready,
    input  logic              m_err,
    output logic              busy,
    input  logic [1:0]        int_en,
    input  logic [1:0]        int_clr,
    output logic              raw_tc,
    output logic              raw_err,
    output logic              irq_tc,
    output logic              irq_err
);
    localparam int LW = $clog2(FIFO_DEPTH + 1);

    logic            endian_q, raw_tc_q, raw_err_q;
    logic            push, pop, flush, done_tc, err_evt;
    wid_e            cur_width;
    logic [DW-1:0]   rd_unit, fifo_head;
    logic [LW-1:0]   fifo_level;

    sgdma_engine #(.DEPTH(FIFO_DEPTH)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .start      (cfg_start),
        .cfg_src    (cfg_src),
        .cfg_dst    (cfg_dst),
        .cfg_next   (cfg_next),
        .cfg_ctrl   (ctrl_t'(cfg_ctrl)),
        .req_single (req_single),
        .req_burst  (req_burst),
        .m_ready    (m_ready),
        .m_err      (m_err),
        .m_rdata    (m_rdata),
        .m_valid    (m_valid),
        .m_write    (m_write),
        .m_addr     (m_addr),
        .cur_width  (cur_width),
        .busy       (busy),
        .push       (push),
        .pop        (pop),
        .flush      (flush),
        .req_done   (req_done),
        .done_tc    (done_tc),
        .err_evt    (err_evt)
    );

    sgdma_lanes u_lanes (
        .rd_word (m_rdata),
        .wr_unit (fifo_head),
        .addr_lo (m_addr[1:0]),
        .width   (cur_width),
        .big     (endian_q),
        .rd_unit (rd_unit),
        .wr_word (m_wdata),
        .wr_strb (m_strb)
    );

    sgdma_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (flush),
        .push  (push),
        .pop   (pop),
        .din   (rd_unit),
        .dout  (fifo_head),
        .level (fifo_level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            endian_q  <= 1'b0;
            raw_tc_q  <= 1'b0;
            raw_err_q <= 1'b0;
        end else begin
            if (cfg_start && !busy) endian_q <= cfg_big_endian;
            if (done_tc)         raw_tc_q <= 1'b1;
            else if (int_clr[0]) raw_tc_q <= 1'b0;
            if (err_evt)         raw_err_q <= 1'b1;
            else if (int_clr[1]) raw_err_q <= 1'b0;
        end
    end

    assign raw_tc  = raw_tc_q;
    assign raw_err = raw_err_q;
    assign irq_tc  = raw_tc_q & int_en[0];
    assign irq_err = raw_err_q & int_en[1];

endmodule

// File: rtl/sgdma_chk.sv
module sgdma_chk
    import sgdma_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       m_valid,
    input logic                       m_ready,
    input logic                       m_err,
    input logic                       m_write,
    input logic [AW-1:0]              m_addr,
    input logic [3:0]                 m_strb,
    input logic                       busy,
    input logic                       raw_tc,
    input logic                       raw_err,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level,
    input wid_e                       cur_width
);
    a_r2_fifo_bound: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= ($clog2(DEPTH+1))'(DEPTH));

    a_r2_write_has_data: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_write) |-> (fifo_level != '0));

    a_r4_byte_one_strobe: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_write && cur_width == WID_8) |-> ($countones(m_strb) == 1));

    a_r8_tc_at_chain_end: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_tc) |-> ($past(busy) && !busy));

    a_r9_err_stops: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready && m_err) |=> (!busy && raw_err));

    a_r10_hold_request: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)));

endmodule

bind sg_dma_chan sgdma_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_err      (m_err),
    .m_write    (m_write),
    .m_addr     (m_addr),
    .m_strb     (m_strb),
    .busy       (busy),
    .raw_tc     (raw_tc),
    .raw_err    (raw_err),
    .fifo_level (fifo_level),
    .cur_width  (cur_width)
);

// File: tb/tb_sg_dma_chan.sv
module tb_sg_dma_chan;

    typedef struct packed {
        logic [11:0] src;
        logic [11:0] dst;
        logic [11:0] cnt;
        logic [1:0]  wid;
        logic        si;
        logic        di;
        logic [1:0]  burst;
        logic        be;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{12'h010, 12'h400, 12'd8, 2'd2, 1'b1, 1'b1, 2'd2, 1'b0},
        '{12'h021, 12'h431, 12'd7, 2'd0, 1'b1, 1'b1, 2'd1, 1'b0},
        '{12'h042, 12'h482, 12'd5, 2'd1, 1'b1, 1'b1, 2'd0, 1'b1},
        '{12'h013, 12'h4C1, 12'd9, 2'd0, 1'b1, 1'b1, 2'd2, 1'b1},
        '{12'h050, 12'h500, 12'd4, 2'd2, 1'b1, 1'b0, 2'd3, 1'b0},
        '{12'h062, 12'h540, 12'd3, 2'd1, 1'b0, 1'b1, 2'd1, 1'b1},
        '{12'h070, 12'h580, 12'd0, 2'd2, 1'b1, 1'b1, 2'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_start = 1'b0;
    logic [31:0] cfg_src = '0, cfg_dst = '0, cfg_next = '0;
    logic [19:0] cfg_ctrl = '0;
    logic        cfg_big_endian = 1'b0;
    logic        req_single = 1'b0, req_burst = 1'b0;
    logic        req_done, m_valid, m_write, m_ready, m_err, busy;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [3:0]  m_strb;
    logic [1:0]  int_en = 2'b00, int_clr = 2'b00;
    logic        raw_tc, raw_err, irq_tc, irq_err;

    logic [7:0]  mem [4096];
    logic [7:0]  exp_mem [4096];
    logic        be_mode = 1'b0;
    logic        tog = 1'b0;
    logic        mon_clr = 1'b0;
    int          writes, run, max_run, tc_early, cyc;
    logic [3:0]  first_strb;
    int          errors = 0, checks = 0;
    logic [11:0] base;

    always #4 clk = ~clk;

    sg_dma_chan dut (
        .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_src(cfg_src),
        .cfg_dst(cfg_dst), .cfg_next(cfg_next), .cfg_ctrl(cfg_ctrl),
        .cfg_big_endian(cfg_big_endian), .req_single(req_single),
        .req_burst(req_burst), .req_done(req_done), .m_valid(m_valid),
        .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata), .m_strb(m_strb),
        .m_rdata(m_rdata), .m_ready(m_ready), .m_err(m_err), .busy(busy),
        .int_en(int_en), .int_clr(int_clr), .raw_tc(raw_tc), .raw_err(raw_err),
        .irq_tc(irq_tc), .irq_err(irq_err)
    );

    // Memory model: one wait cycle per access, error in the top address region
    assign base    = {m_addr[11:2], 2'b00};
    assign m_ready = m_valid & tog;
    assign m_err   = m_ready & (m_addr[31:28] == 4'hF);
    assign m_rdata = be_mode ? {mem[base], mem[base+1], mem[base+2], mem[base+3]}
                             : {mem[base+3], mem[base+2], mem[base+1], mem[base]};

    always @(posedge clk) begin
        tog <= m_valid ? ~tog : 1'b0;
        cyc <= cyc + 1;
        if (mon_clr) begin
            writes <= 0; run <= 0; max_run <= 0; tc_early <= 0; first_strb <= 4'b0;
        end else begin
            if (raw_tc && busy) tc_early <= 1;
            if (m_valid && m_ready && !m_err) begin
                if (m_write) begin
                    for (int i = 0; i < 4; i++)
                        if (m_strb[i])
                            mem[be_mode ? base + 12'(3 - i) : base + 12'(i)] <= m_wdata[8*i +: 8];
                    if (writes == 0) first_strb <= m_strb;
                    writes <= writes + 1;
                    run <= 0;
                end else begin
                    run <= run + 1;
                    if (run + 1 > max_run) max_run <= run + 1;
                end
            end
        end
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected=<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] mk_ctrl(int cnt, int burst, int wid, bit si, bit di,
                                            bit tc, bit fr);
        return {fr, tc, di, si, 2'(wid), 2'(burst), 12'(cnt)};
    endfunction

    function automatic int nbytes(int wid);
        return (wid == 0) ? 1 : (wid == 1) ? 2 : 4;
    endfunction

    task automatic fill_mem(input int seed);
        for (int i = 0; i < 4096; i++) begin
            mem[i]     = 8'(i * 13 + seed);
            exp_mem[i] = 8'(i * 13 + seed);
        end
    endtask

    task automatic put_word(input int addr, input logic [31:0] w);
        for (int b = 0; b < 4; b++) begin
            mem[addr + b]     = w[8*b +: 8];
            exp_mem[addr + b] = w[8*b +: 8];
        end
    endtask

    task automatic exp_copy(input int s, input int d, input int cnt, input int wid,
                            input bit si, input bit di);
        int nb;
        nb = nbytes(wid);
        for (int k = 0; k < cnt; k++)
            for (int b = 0; b < nb; b++)
                exp_mem[(d + (di ? k * nb : 0) + b) % 4096] =
                    exp_mem[(s + (si ? k * nb : 0) + b) % 4096];
    endtask

    task automatic mem_compare(input string req);
        int bad, first;
        bad = 0; first = -1;
        for (int i = 0; i < 4096; i++)
            if (mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        chk(bad == 0, req, bad, 0);
        if (bad != 0)
            $display("  first mismatch at %0h: %0h vs %0h", first, mem[first], exp_mem[first]);
    endtask

    task automatic start_xfer(input logic [31:0] s, input logic [31:0] d,
                              input logic [31:0] nxt, input logic [19:0] c, input bit be);
        @(negedge clk);
        int_clr  = 2'b11;
        mon_clr  = 1'b1;
        be_mode  = be;
        @(negedge clk);
        int_clr  = 2'b00;
        mon_clr  = 1'b0;
        cfg_src = s; cfg_dst = d; cfg_next = nxt; cfg_ctrl = c; cfg_big_endian = be;
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_req_done();
        while (!req_done) @(negedge clk);
        req_burst  = 1'b0;
        req_single = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int exp_run, nb, lane;
        logic [3:0] exp_strb;
        cyc = 0;
        fill_mem(0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(busy == 1'b0,    "R1 busy after reset",    busy, 0);
        chk(m_valid == 1'b0, "R1 m_valid after reset", m_valid, 0);
        chk(raw_tc == 1'b0,  "R1 raw_tc after reset",  raw_tc, 0);
        chk(raw_err == 1'b0, "R1 raw_err after reset", raw_err, 0);
        chk(irq_tc == 1'b0 && irq_err == 1'b0, "R1 irqs after reset", {irq_tc, irq_err}, 0);

        // Vector table: free-running single-block copies
        for (int v = 0; v < NV; v++) begin
            fill_mem(v * 5 + 1);
            exp_copy(VECS[v].src, VECS[v].dst, VECS[v].cnt, VECS[v].wid,
                     VECS[v].si, VECS[v].di);
            start_xfer(32'(VECS[v].src), 32'(VECS[v].dst), 32'h0,
                       mk_ctrl(VECS[v].cnt, VECS[v].burst, VECS[v].wid,
                               VECS[v].si, VECS[v].di, 1'b1, 1'b1), VECS[v].be);
            wait_idle();
            mem_compare("R1/R3 copied memory");
            chk(writes == int'(VECS[v].cnt), "R3 write beats", writes, VECS[v].cnt);
            exp_run = 1 << VECS[v].burst;
            if (exp_run > 4) exp_run = 4;
            if (exp_run > int'(VECS[v].cnt)) exp_run = VECS[v].cnt;
            chk(max_run == exp_run, "R2 longest read run per chunk", max_run, exp_run);
            chk(raw_tc == 1'b1, "R8 raw_tc at end", raw_tc, 1);
            if (VECS[v].cnt != 0) begin
                nb   = nbytes(VECS[v].wid);
                lane = VECS[v].be ? 4 - int'(VECS[v].dst[1:0]) - nb : int'(VECS[v].dst[1:0]);
                exp_strb = 4'(((1 << nb) - 1) << lane);
                chk(first_strb == exp_strb,
                    VECS[v].be ? "R5 big-endian strobe" : "R4 little-endian strobe",
                    first_strb, exp_strb);
            end
        end

        // R6: request pacing, burst 4 units, 6 units total
        fill_mem(40);
        exp_copy(12'h200, 12'h800, 6, 2, 1, 1);
        start_xfer(32'h200, 32'h800, 32'h0, mk_ctrl(6, 2, 2, 1, 1, 1, 0), 1'b0);
        repeat (10) @(negedge clk);
        chk(writes == 0 && busy, "R6 no movement without request", writes, 0);
        req_burst = 1'b1;
        wait_req_done();
        chk(writes == 4, "R6 burst request moves a burst", writes, 4);
        req_single = 1'b1;
        wait_req_done();
        chk(writes == 5, "R6 single request moves one unit", writes, 5);
        chk(busy == 1'b1 && raw_tc == 1'b0, "R8 no tc before block end", raw_tc, 0);
        req_burst = 1'b1;
        wait_req_done();
        wait_idle();
        chk(writes == 6, "R6 burst clipped to remaining units", writes, 6);
        mem_compare("R6 paced copy memory");

        // R7/R8: three-block chain built from descriptors
        fill_mem(77);
        put_word(12'h300, 32'h120); put_word(12'h304, 32'h620);
        put_word(12'h308, 32'h310); put_word(12'h30C, 32'(mk_ctrl(3, 1, 1, 1, 1, 0, 1)));
        put_word(12'h310, 32'h130); put_word(12'h314, 32'h641);
        put_word(12'h318, 32'h0);   put_word(12'h31C, 32'(mk_ctrl(5, 2, 0, 1, 1, 1, 1)));
        exp_copy(12'h100, 12'h600, 4, 2, 1, 1);
        exp_copy(12'h120, 12'h620, 3, 1, 1, 1);
        exp_copy(12'h130, 12'h641, 5, 0, 1, 1);
        start_xfer(32'h100, 32'h600, 32'h300, mk_ctrl(4, 2, 2, 1, 1, 1, 1), 1'b0);
        wait_idle();
        mem_compare("R7 chained copy memory");
        chk(writes == 12, "R7 chained write beats", writes, 12);
        chk(tc_early == 0, "R8 tc not raised mid-chain", tc_early, 0);
        chk(raw_tc == 1'b1, "R8 tc after final block", raw_tc, 1);

        // R8: final block with interrupt bit clear
        start_xfer(32'h100, 32'h700, 32'h0, mk_ctrl(2, 0, 2, 1, 1, 0, 1), 1'b0);
        wait_idle();
        chk(raw_tc == 1'b0, "R8 no tc when bit clear", raw_tc, 0);

        // R8: masking and clear
        start_xfer(32'h100, 32'h700, 32'h0, mk_ctrl(1, 0, 2, 1, 1, 1, 1), 1'b0);
        wait_idle();
        chk(raw_tc == 1'b1 && irq_tc == 1'b0, "R8 masked irq_tc low", irq_tc, 0);
        int_en = 2'b01;
        @(negedge clk);
        chk(irq_tc == 1'b1, "R8 enabled irq_tc high", irq_tc, 1);
        int_clr = 2'b01;
        @(negedge clk);
        int_clr = 2'b00;
        @(negedge clk);
        chk(raw_tc == 1'b0 && irq_tc == 1'b0, "R8 clear raw_tc", raw_tc, 0);

        // R9: data read error
        int_en = 2'b10;
        start_xfer(32'hF000_0000, 32'h700, 32'h0, mk_ctrl(4, 2, 2, 1, 1, 1, 1), 1'b0);
        wait_idle();
        chk(raw_err == 1'b1, "R9 raw_err on read error", raw_err, 1);
        chk(irq_err == 1'b1, "R9 irq_err enabled", irq_err, 1);
        chk(writes == 0 && raw_tc == 1'b0, "R9 no writes or tc after abort", writes, 0);

        // R9: descriptor fetch error after one good block
        fill_mem(90);
        exp_copy(12'h100, 12'h700, 2, 2, 1, 1);
        start_xfer(32'h100, 32'h700, 32'hF000_0010, mk_ctrl(2, 1, 2, 1, 1, 1, 1), 1'b0);
        wait_idle();
        chk(raw_err == 1'b1 && busy == 1'b0, "R9 descriptor error stops channel", raw_err, 1);
        mem_compare("R9 block before error intact");
        int_clr = 2'b10;
        @(negedge clk);
        int_clr = 2'b00;
        @(negedge clk);
        chk(raw_err == 1'b0 && irq_err == 1'b0, "R9 clear raw_err", raw_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule